// File: doc/BRIEF.md
# GPIO Interrupt Bank

A bank of general-purpose pins with one interrupt detector per pin, configured and observed through a small 32-bit register port. For every pin the bank holds a drive value, a drive enable and a pull-resistor setting. It samples the pad inputs through a two-flop synchronizer. Each pin can raise an event on a level or on an edge. An edge can be a single edge of a chosen polarity or both edges.

Events latch into a raw status register. A per-pin enable mask turns raw status into pending status. Software acknowledges a pin by writing a one to its bit in the acknowledge register. One registered interrupt line reports that at least one pending bit is set. Pads are modelled as separate input, drive-value and drive-enable vectors. The pull setting is presented as decoded pull-up and pull-down vectors.

The register port is a plain control interface rather than a stream. Every cycle the port accepts a write when write enable is high. Every cycle `reg_rdata` returns, one cycle later, the word at the address presented. There is no back-pressure.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pad_oe`, `pad_out`, both pull vectors and `irq` are zero. All pins start in falling-edge mode with their interrupts masked.
- R2: Byte offset 0x04 holds the drive value and 0x08 holds the drive enable. Both read back, and they appear on `pad_out` and `pad_oe` the cycle after the write. A 1 in the drive enable means the pin is driven.
- R3: Pull enable is at offset 0x38 and pull direction at offset 0x34. For a pin with pull enable 1, `pull_up_o` equals the direction bit and `pull_dn_o` equals its inverse. For a pin with pull enable 0, both outputs are 0.
- R4: A read of offset 0x00 returns `pad_in` after two synchronizer flops. A change made just before clock edge k is not seen by a read whose address is sampled at edge k. After three cycles the change is visible.
- R5: A 1 in the sense register (0x0C) makes a pin level-sensitive. With polarity (0x14) set to 1 the pin triggers on a high level, and with 0 on a low level. While the level persists, raw status is set again each cycle, even after an acknowledge.
- R6: With sense 0 and both-edges (0x10) 0, a pin with polarity 1 latches on a rising edge and one with polarity 0 on a falling edge. The opposite edge sets nothing. The bit stays set until it is acknowledged.
- R7: With sense 0 and both-edges 1, rising and falling edges both latch, whatever the polarity bit holds.
- R8: Offset 0x1C reads raw status. Offset 0x20 reads raw status AND the enable mask at 0x18. `irq` is 1 the cycle after any bit of that pending value is 1.
- R9: Writing the acknowledge register (0x24) clears each raw status bit written as 1 and leaves bits written as 0 unchanged. A read of 0x24 always returns zero.
- R10: If an acknowledge and a new event for the same pin fall in the same cycle, the raw status bit stays 1.
- R11: Reads of unmapped offsets (e.g. 0x28, 0x2C, 0x30) return zero. Writes to them, and writes to the read-only offsets 0x00, 0x1C and 0x20, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write enable for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad drive enables, 1 = driven |
| pull_up_o | output | 32 | Pull-up resistor enables |
| pull_dn_o | output | 32 | Pull-down resistor enables |
| irq | output | 1 | Combined registered interrupt |

## Verification
A corrupt synchronizer or previous-sample flop shows up first as a wrong value at offset 0x00. It also shows up as a spurious or missing status bit at 0x1C, three cycles after the pad change. A raw status bit that sticks, or that is lost on an acknowledge, is visible on the next read of 0x1C. It is also visible on `irq` one cycle after the pending value changes, provided the pin is enabled. Configuration faults show directly on the pad and pull vectors the cycle after the write. The collision and level re-trigger cases are driven with cycle-exact timing, so that a design which lets the acknowledge win is caught on the very next read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;

  // Byte offsets; software depends on these positions.
  localparam logic [ADDR_W-1:0] OFS_PIN_IN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DRV_VAL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DRV_EN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SENSE_LVL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_BOTH_EDGE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_POLARITY  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RAW       = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_PEND      = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ACK       = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_PULL_DIR  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PULL_EN   = 8'h38;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] last
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      last <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] last,
  input  logic [W-1:0] sense_lvl,
  input  logic [W-1:0] both_edge,
  input  logic [W-1:0] polarity,
  output logic [W-1:0] event_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = cur[g] & ~last[g];
    assign fall     = ~cur[g] & last[g];
    assign lvl_hit  = polarity[g] ? cur[g] : ~cur[g];
    assign edge_hit = both_edge[g] ? (rise | fall)
                                   : (polarity[g] ? rise : fall);
    assign event_o[g] = sense_lvl[g] ? lvl_hit : edge_hit;
  end
endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_state,
  input  logic [W-1:0]      event_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      drv_val,
  output logic [W-1:0]      drv_en,
  output logic [W-1:0]      sense_lvl,
  output logic [W-1:0]      both_edge,
  output logic [W-1:0]      polarity,
  output logic [W-1:0]      irq_en,
  output logic [W-1:0]      pull_dir,
  output logic [W-1:0]      pull_en,
  output logic [W-1:0]      raw
);
  logic [W-1:0] ack_bits;
  logic [W-1:0] rd_mux;

  assign ack_bits = (wr && addr == OFS_ACK) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_val   <= '0;
      drv_en    <= '0;
      sense_lvl <= '0;
      both_edge <= '0;
      polarity  <= '0;
      irq_en    <= '0;
      pull_dir  <= '0;
      pull_en   <= '0;
      raw       <= '0;
      rdata     <= '0;
    end else begin
      if (wr) begin
        case (addr)
          OFS_DRV_VAL:   drv_val   <= wdata;
          OFS_DRV_EN:    drv_en    <= wdata;
          OFS_SENSE_LVL: sense_lvl <= wdata;
          OFS_BOTH_EDGE: both_edge <= wdata;
          OFS_POLARITY:  polarity  <= wdata;
          OFS_IRQ_EN:    irq_en    <= wdata;
          OFS_PULL_DIR:  pull_dir  <= wdata;
          OFS_PULL_EN:   pull_en   <= wdata;
          default: ;
        endcase
      end
      // a new event wins over an acknowledge in the same cycle
      raw   <= (raw & ~ack_bits) | event_i;
      rdata <= rd_mux;
    end
  end

  always_comb begin
    case (addr)
      OFS_PIN_IN:    rd_mux = pin_state;
      OFS_DRV_VAL:   rd_mux = drv_val;
      OFS_DRV_EN:    rd_mux = drv_en;
      OFS_SENSE_LVL: rd_mux = sense_lvl;
      OFS_BOTH_EDGE: rd_mux = both_edge;
      OFS_POLARITY:  rd_mux = polarity;
      OFS_IRQ_EN:    rd_mux = irq_en;
      OFS_RAW:       rd_mux = raw;
      OFS_PEND:      rd_mux = pend_i;
      OFS_PULL_DIR:  rd_mux = pull_dir;
      OFS_PULL_EN:   rd_mux = pull_en;
      default:       rd_mux = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o,
  output logic              irq
);
  logic [NPINS-1:0] sync_cur, sync_last, ev_w;
  logic [NPINS-1:0] sense_w, both_w, pol_w, en_w;
  logic [NPINS-1:0] pdir_w, pen_w, raw_w, pend_w;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in),
    .cur(sync_cur), .last(sync_last)
  );

  gpio_event_det #(.W(NPINS)) u_det (
    .cur(sync_cur), .last(sync_last), .sense_lvl(sense_w),
    .both_edge(both_w), .polarity(pol_w), .event_o(ev_w)
  );

  gpio_csr #(.W(NPINS)) u_csr (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pin_state(sync_cur),
    .event_i(ev_w), .pend_i(pend_w), .drv_val(pad_out), .drv_en(pad_oe),
    .sense_lvl(sense_w), .both_edge(both_w), .polarity(pol_w),
    .irq_en(en_w), .pull_dir(pdir_w), .pull_en(pen_w), .raw(raw_w)
  );

  assign pend_w    = raw_w & en_w;
  assign pull_up_o = pen_w & pdir_w;
  assign pull_dn_o = pen_w & ~pdir_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pend_w;
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [NPINS-1:0]  reg_wdata,
  input logic [NPINS-1:0]  reg_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic              irq,
  input logic [NPINS-1:0]  raw_w,
  input logic [NPINS-1:0]  en_w,
  input logic [NPINS-1:0]  ev_w,
  input logic [NPINS-1:0]  sense_w,
  input logic [NPINS-1:0]  sync_cur,
  input logic [NPINS-1:0]  sync_last
);
  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ACK) |=>
      ((raw_w & $past(reg_wdata) & ~$past(ev_w)) == '0));

  // R10
  event_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_w != '0) |=> ((raw_w & $past(ev_w)) == $past(ev_w)));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((raw_w & en_w) != '0));

  // R9
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_ACK) |=> (reg_rdata == '0));

  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_DRV_VAL) |=> $stable(pad_out));

  // R6
  no_edge_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sense_w) & ev_w & ~(sync_cur ^ sync_last)) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_out(pad_out),
  .irq(irq), .raw_w(raw_w), .en_w(en_w), .ev_w(ev_w), .sense_w(sense_w),
  .sync_cur(sync_cur), .sync_last(sync_last)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pull_up_o, pull_dn_o;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up_o(pull_up_o),
    .pull_dn_o(pull_dn_o), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 64; a += 4) begin
      rd_reg(a[7:0], d);
      chk($sformatf("R1 reset read %0h", a), d, 32'h0);
    end
    chk("R1 reset pad_oe", pad_oe, 32'h0);
    chk("R1 reset pad_out", pad_out, 32'h0);
    chk("R1 reset pulls", pull_up_o | pull_dn_o, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    wr_reg(8'h04, 32'hA5A5_0F0F);
    chk("R2 pad_out after write", pad_out, 32'hA5A5_0F0F);
    wr_reg(8'h08, 32'hFFFF_0000);
    chk("R2 pad_oe after write", pad_oe, 32'hFFFF_0000);
    rd_reg(8'h04, d); chk("R2 drive value readback", d, 32'hA5A5_0F0F);
    rd_reg(8'h08, d); chk("R2 drive enable readback", d, 32'hFFFF_0000);
  endtask

  task automatic t_pull();
    wr_reg(8'h34, 32'h0000_00F0);
    wr_reg(8'h38, 32'h0000_00CC);
    chk("R3 pull up", pull_up_o, 32'h0000_00C0);
    chk("R3 pull down", pull_dn_o, 32'h0000_000C);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    reg_addr = 8'h00;
    @(negedge clk);
    chk("R4 sync latency old value", reg_rdata, 32'h0);
    cyc(3);
    rd_reg(8'h00, d);
    chk("R4 input after sync", d, 32'h1234_5678);
    set_pad(32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr_reg(8'h0C, 32'h0000_0028);   // pins 3 and 5 level
    wr_reg(8'h14, 32'h0000_0008);   // pin 3 high, pin 5 low
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_reg(8'h1C, d);
    chk("R5 active-low pin set at low level", d & 32'h28, 32'h20);
    set_pad(32'h0000_0028);
    wr_reg(8'h24, 32'h0000_0028);
    rd_reg(8'h1C, d);
    chk("R5 high level re-sets after ack", d & 32'h28, 32'h08);
    set_pad(32'h0);
    wr_reg(8'h24, 32'h0000_0008);
    rd_reg(8'h1C, d);
    chk("R5 level gone, ack clears", d & 32'h08, 32'h0);
    wr_reg(8'h0C, 32'h0);
    wr_reg(8'h14, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr_reg(8'h14, 32'h0000_0100);   // pin 8 rising, pin 9 falling
    set_pad(32'h0000_0200);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    set_pad(32'h0000_0100);         // 8 rises, 9 falls
    cyc(3);
    rd_reg(8'h1C, d);
    chk("R6 chosen edges latch and hold", d & 32'h300, 32'h300);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    set_pad(32'h0000_0200);         // 8 falls, 9 rises
    rd_reg(8'h1C, d);
    chk("R6 opposite edges ignored", d & 32'h300, 32'h0);
    set_pad(32'h0);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    wr_reg(8'h14, 32'h0);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    wr_reg(8'h10, 32'h0000_3000);   // pins 12,13 both edges
    wr_reg(8'h14, 32'h0000_2000);   // polarity differs, must not matter
    wr_reg(8'h24, 32'hFFFF_FFFF);
    set_pad(32'h0000_3000);
    rd_reg(8'h1C, d);
    chk("R7 both-edge rising", d & 32'h3000, 32'h3000);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    set_pad(32'h0);
    rd_reg(8'h1C, d);
    chk("R7 both-edge falling", d & 32'h3000, 32'h3000);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    wr_reg(8'h10, 32'h0);
    wr_reg(8'h14, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr_reg(8'h14, 32'h0010_0000);   // pin 20 rising
    wr_reg(8'h24, 32'hFFFF_FFFF);
    set_pad(32'h0010_0000);
    rd_reg(8'h1C, d); chk("R8 raw set while masked", d & 32'h0010_0000, 32'h0010_0000);
    rd_reg(8'h20, d); chk("R8 pending zero while masked", d, 32'h0);
    chk("R8 irq low while masked", {31'h0, irq}, 32'h0);
    wr_reg(8'h18, 32'h0010_0000);
    chk("R8 irq not yet (registered)", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq one cycle after pending", {31'h0, irq}, 32'h1);
    rd_reg(8'h20, d); chk("R8 pending value", d, 32'h0010_0000);
    wr_reg(8'h24, 32'h0);
    rd_reg(8'h1C, d); chk("R9 ack of zero leaves bit", d & 32'h0010_0000, 32'h0010_0000);
    rd_reg(8'h24, d); chk("R9 ack reads zero", d, 32'h0);
    wr_reg(8'h24, 32'h0010_0000);
    @(negedge clk);
    chk("R9 ack clears, irq drops", {31'h0, irq}, 32'h0);
    rd_reg(8'h1C, d); chk("R9 raw cleared", d & 32'h0010_0000, 32'h0);
    wr_reg(8'h18, 32'h0);
    set_pad(32'h0);
    wr_reg(8'h14, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr_reg(8'h14, 32'h0100_0000);   // pin 24 rising
    wr_reg(8'h24, 32'hFFFF_FFFF);
    @(negedge clk);
    pad_in = 32'h0100_0000;         // before edge k
    @(negedge clk);                 // after edge k
    @(negedge clk);                 // after k+1: event window open
    reg_addr = 8'h24; reg_wr = 1'b1; reg_wdata = 32'h0100_0000;
    @(negedge clk);                 // ack and event at edge k+2
    reg_wr = 1'b0;
    rd_reg(8'h1C, d);
    chk("R10 event wins over ack", d & 32'h0100_0000, 32'h0100_0000);
    wr_reg(8'h24, 32'h0100_0000);
    rd_reg(8'h1C, d);
    chk("R10 later ack clears", d & 32'h0100_0000, 32'h0);
    set_pad(32'h0);
    wr_reg(8'h14, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr_reg(8'h24, 32'hFFFF_FFFF);
    wr_reg(8'h28, 32'hFFFF_FFFF);
    wr_reg(8'h2C, 32'hFFFF_FFFF);
    wr_reg(8'h30, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_reg(8'h28, d); chk("R11 unmapped 0x28 reads zero", d, 32'h0);
    rd_reg(8'h30, d); chk("R11 unmapped 0x30 reads zero", d, 32'h0);
    rd_reg(8'h1C, d); chk("R11 raw not writable", d, 32'h0);
    rd_reg(8'h00, d); chk("R11 input not writable", d, 32'h0);
    rd_reg(8'h04, d); chk("R11 drive value untouched", d, 32'hA5A5_0F0F);
    rd_reg(8'h18, d); chk("R11 mask untouched", d, 32'h0);
    chk("R11 irq stays low", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_drive();
    t_pull();
    t_input();
    t_level();
    t_edge();
    t_dual();
    t_mask();
    t_collide();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule